// File: doc/BRIEF.md
# Folding Converter Fine/Coarse Encoder

This block is the digital back end of a four-bit folding analog-to-digital converter that folds four times. A two-bit coarse converter reports which quarter of full scale holds the input. Four folder comparators each cross zero once in every quarter, at offsets of one, two, three and four sixteenths of full scale into that quarter. Their latched outputs give a thermometer pattern that locates the input inside the quarter.

The folder slope rises in even quarters and falls in odd quarters. In odd quarters the fine pattern therefore arrives inverted. The encoder takes the fold direction from the low coarse bit. It counts the matching folder bits, which is ones for rising and zeros for falling, and saturates the count at three. The coarse bits become the high half of the result and the count becomes the low half. The result is registered one clock after an input-valid strobe.

The control is a two-state machine. `ST_EMPTY` means no result is presented. `ST_FULL` means a result is presented. The transitions are:
- `ST_EMPTY` to `ST_FULL` on `in_valid` (capture).
- `ST_FULL` to `ST_FULL` on `in_valid` (back-to-back capture).
- `ST_FULL` to `ST_EMPTY` when `in_valid` is low (drain).
- `ST_EMPTY` stays `ST_EMPTY` when `in_valid` is low (idle).

Top module: `fold_encoder`

## Requirements
- R1: While `rst_n` is low and right after it rises, `out_valid` is 0 and `code_out` is 0.
- R2: `out_valid` is 1 in the cycle after a clock edge that sees `in_valid` high, and 0 after an edge that sees it low.
- R3: On a capture, `code_out[3:2]` equals the `coarse_in` value sampled at that edge.
- R4: When `coarse_in[0]` is 0 (rising fold), `code_out[1:0]` is the number of ones in `fold_in`.
- R5: When `coarse_in[0]` is 1 (falling fold), `code_out[1:0]` is the number of zeros in `fold_in`.
- R6: A fine pattern that is not a thermometer code (a bubble) is decoded by count and not by transition position. For example, `fold_in`=4'b0101 in a rising quarter gives fine value 2.
- R7: The fine count saturates at 3. A count of four gives 3, for example `fold_in`=4'b1111 rising or 4'b0000 falling.
- R8: An edge with `in_valid` low leaves `code_out` unchanged, whatever `coarse_in` and `fold_in` carry.
- R9: For every integer input 0 to 15 with ideal folder outputs, `code_out` equals that input. Folder k (bit k, k=0..3) is 1 when the offset within the quarter is at least k+1, and that value is inverted in odd quarters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coarse and fold inputs are valid this cycle |
| coarse_in | input | 2 | Quarter index from the coarse converter |
| fold_in | input | 4 | Latched folder comparator outputs, bit k is folder k |
| out_valid | output | 1 | `code_out` holds a fresh result |
| code_out | output | 4 | Binary conversion result |

## Verification
The assertions watch several rules on every cycle: the one-cycle valid latency, the coarse bits reaching the high half of the result, and the result holding when no strobe arrives. The decode itself can only be shown by the bench's scenarios. That covers direction selection, bubble handling and saturation, and the full sweep of sixteen ideal inputs, because these depend on the values of the fold patterns and not on timing relations.

// File: rtl/fold_enc_pkg.sv
package fold_enc_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } enc_state_t;
endpackage

// File: rtl/fold_fine_count.sv
module fold_fine_count #(
    parameter int FOLDS  = 4,
    parameter int FINE_W = $clog2(FOLDS)
) (
    input  logic [FOLDS-1:0]  fold,
    input  logic              falling,
    output logic [FINE_W-1:0] fine
);
    localparam logic [FINE_W:0] FINE_MAX = (FINE_W+1)'(FOLDS - 1);

    logic [FOLDS-1:0] aligned;
    logic [FINE_W:0]  tally;

    // Align every folder to a rising slope before counting.
    genvar g;
    generate
        for (g = 0; g < FOLDS; g++) begin : g_align
            assign aligned[g] = fold[g] ^ falling;
        end
    endgenerate

    always_comb begin
        tally = '0;
        for (int i = 0; i < FOLDS; i++) begin
            tally = tally + {{FINE_W{1'b0}}, aligned[i]};
        end
        if (tally > FINE_MAX) begin
            fine = FINE_MAX[FINE_W-1:0];
        end else begin
            fine = tally[FINE_W-1:0];
        end
    end
endmodule

// File: rtl/fold_enc_fsm.sv
module fold_enc_fsm
    import fold_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic load,
    output logic out_valid
);
    enc_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: state_nx = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_comb begin
        load      = in_valid;
        out_valid = 1'b0;
        unique case (state)
            ST_EMPTY: out_valid = 1'b0;
            ST_FULL:  out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end

    // R2
    latency_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/fold_encoder.sv
module fold_encoder #(
    parameter int COARSE_W = 2,
    parameter int FOLDS    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [COARSE_W-1:0]          coarse_in,
    input  logic [FOLDS-1:0]             fold_in,
    output logic                         out_valid,
    output logic [COARSE_W+$clog2(FOLDS)-1:0] code_out
);
    localparam int FINE_W = $clog2(FOLDS);
    localparam int CODE_W = COARSE_W + FINE_W;

    logic              load;
    logic [FINE_W-1:0] fine;

    fold_enc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .load      (load),
        .out_valid (out_valid)
    );

    // The low coarse bit selects the fold direction: 1 means falling.
    fold_fine_count #(
        .FOLDS  (FOLDS),
        .FINE_W (FINE_W)
    ) u_count (
        .fold    (fold_in),
        .falling (coarse_in[0]),
        .fine    (fine)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_out <= '0;
        end else if (load) begin
            code_out <= {coarse_in, fine};
        end
    end

    // R3
    coarse_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (code_out[CODE_W-1:FINE_W] == $past(coarse_in)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(code_out));
endmodule

// File: tb/test_fold_encoder.sv
module test_fold_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] coarse_in = '0;
    logic [3:0] fold_in = '0;
    logic       out_valid;
    logic [3:0] code_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fold_encoder i_fold_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .coarse_in (coarse_in),
        .fold_in   (fold_in),
        .out_valid (out_valid),
        .code_out  (code_out)
    );

    // {coarse, fold, expected code}: R4 R5 R6 R7 cases
    localparam logic [9:0] VEC [8] = '{
        {2'd0, 4'b0101, 4'h2},  // R6 bubble, rising
        {2'd2, 4'b1111, 4'hB},  // R7 saturation, rising
        {2'd1, 4'b0000, 4'h7},  // R7 saturation, falling
        {2'd3, 4'b1010, 4'hE},  // R5 R6 falling bubble
        {2'd0, 4'b0000, 4'h0},  // R4 empty
        {2'd1, 4'b1111, 4'h4},  // R5 all ones falling
        {2'd2, 4'b0010, 4'h9},  // R4 R6 single bubble
        {2'd3, 4'b1011, 4'hD}   // R5 one zero
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ideal_fold(input int x);
        logic [3:0] f;
        for (int k = 0; k < 4; k++) begin
            f[k] = ((x % 4) >= k + 1);
            if ((x / 4) % 2 == 1) f[k] = ~f[k];
        end
        return f;
    endfunction

    task automatic apply(input logic [1:0] c, input logic [3:0] f);
        @(negedge clk);
        in_valid  = 1'b1;
        coarse_in = c;
        fold_in   = f;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        // R1 reset state
        #23;
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        check(code_out == 4'h0, "R1 code in reset", code_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        check(code_out == 4'h0, "R1 code after reset", code_out, 0);

        // Table walk: R4 R5 R6 R7 and R3
        for (int i = 0; i < 8; i++) begin
            apply(VEC[i][9:8], VEC[i][7:4]);
            check(out_valid == 1'b1, "R2 valid after strobe", out_valid, 1);
            check(code_out == VEC[i][3:0], "R3 R4 R5 R6 R7 table", code_out, VEC[i][3:0]);
        end

        // R9 ideal sweep
        for (int x = 0; x < 16; x++) begin
            apply(2'(x / 4), ideal_fold(x));
            check(code_out == 4'(x), "R9 ideal sweep", code_out, x);
        end

        // R2 latency and drain, R8 hold
        apply(2'd2, 4'b0011);
        check(code_out == 4'hA, "R4 before hold", code_out, 10);
        coarse_in = 2'd1;
        fold_in   = 4'b1000;
        @(negedge clk);
        check(out_valid == 1'b0, "R2 drain", out_valid, 0);
        check(code_out == 4'hA, "R8 hold ignores inputs", code_out, 10);

        // R2 back-to-back
        @(negedge clk);
        in_valid = 1'b1; coarse_in = 2'd3; fold_in = 4'b1100;
        @(negedge clk);
        check(out_valid == 1'b1 && code_out == 4'hE, "R2 first of pair", code_out, 14);
        coarse_in = 2'd0; fold_in = 4'b0001;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1 && code_out == 4'h1, "R2 second of pair", code_out, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule